// File: doc/BRIEF.md
# Programmable Input Pin Toggler

The block drives stimulus onto an 8-bit input port. It holds a small set of independent generators. Each generator picks one pin of the port and flips that pin's level again and again. The time spent high and the time spent low are set separately. A count sets how many further flips follow the first one. Every time value is counted in bus cycles, and one bus cycle is four clock cycles.

The port value that leaves the block is the incoming port value with each claimed pin replaced by the level of the generator that owns it. The other pins pass through untouched.

Software works the block through a one-cycle command bus. A command can:
- write a generator's pin selection, high time, low time or repeat count;
- start a generator;
- clear a generator.

A separate halt input models a system reset event. It stops every running generator at once and keeps their settings. A busy vector shows which generators still have a flip pending.

Top module: `pin_toggler`

## Requirements
- R1: After reset every generator is idle with level 0 and no pin claimed, so `pin_out` equals `pin_in` and `gen_busy` is 0.
- R2: A command acts when `op_valid` is 1, on the generator numbered `op_gen`. The `op_code` encoding is: 0 = pin select, 1 = high time, 2 = low time, 3 = repeat count, 4 = start, 5 = clear. Codes 6 and 7 do nothing, and an `op_gen` of `NUM_GEN` or more does nothing.
- R3: A pin-select write stores the lowest set bit of `op_data[7:0] & ALLOW_MASK` (default 8'h87), or nothing when that is zero. A generator with a pin drives that pin with its level. When two generators claim the same pin, the lower-numbered one wins.
- R4: Times are counted in bus cycles of `CLK_PER_BUS` (4) clocks. A flip happens 4*D clocks after the edge that accepts the start, where D is the interval in use. A time written as 0 is stored as 1.
- R5: After a flip to high, the next interval is the high time. After a flip to low, the next interval is the low time.
- R6: Each flip that schedules another one decrements the repeat count. A start with repeat count N gives N+1 flips, after which the generator goes idle and keeps its last level.
- R7: A start cancels any pending flip. It begins a fresh interval: the high time if the level is currently 1, otherwise the low time.
- R8: A start whose chosen interval was never written (still 0) leaves the generator idle. A flip whose next interval was never written ends the run.
- R9: A clear cancels the pending flip and sets the repeat count to 0. The level and the pin are kept.
- R10: Raising `halt_all` for one cycle cancels every pending flip and keeps every setting, so a later start runs normally.
- R11: `gen_busy[i]` is 1 exactly while generator i has a flip pending.
- R12: Pins outside `ALLOW_MASK` always equal `pin_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Command strobe |
| op_code | input | 3 | Command code |
| op_gen | input | 3 | Target generator number |
| op_data | input | 32 | Command data: pin bits or count |
| halt_all | input | 1 | Cancel all pending flips |
| pin_in | input | 8 | Incoming port value |
| pin_out | output | 8 | Port value with claimed pins replaced |
| gen_busy | output | 4 | Per-generator pending-flip flag |

## Verification
The assertions assume that a command strobe lasts one cycle. They also assume that `halt_all` and a clear never coincide with a write of the repeat count to the same generator. The directed stimulus issues one command per cycle and raises `halt_all` only between commands.

The checks cover:
- the exact flip cycle, sampled one clock before and at the expiry edge;
- the choice of interval taken from the current level;
- the number of flips a repeat count yields;
- that a restart, a clear or a halt lands before the flip that would otherwise have occurred.

// File: rtl/tgl_pkg.sv
// Package: shared command codes and per-generator control strobes.
// Assumes: a command is one cycle wide and targets a single generator.
package tgl_pkg;

    typedef enum logic [2:0] {
        OP_PIN   = 3'd0,
        OP_HIGH  = 3'd1,
        OP_LOW   = 3'd2,
        OP_COUNT = 3'd3,
        OP_START = 3'd4,
        OP_CLEAR = 3'd5
    } tgl_op_e;

    typedef struct packed {
        logic wr_pin;
        logic wr_high;
        logic wr_low;
        logic wr_count;
        logic start;
        logic clear;
    } tgl_ctl_t;

endpackage

// File: rtl/tgl_decode.sv
// Module: turns the command bus into per-generator one-cycle strobes.
// Assumes: out-of-range generator numbers and unknown codes are dropped.
module tgl_decode
    import tgl_pkg::*;
#(
    parameter int NUM_GEN = 4,
    parameter int SEL_W   = 3
) (
    input  logic             op_valid,
    input  logic [2:0]       op_code,
    input  logic [SEL_W-1:0] op_gen,
    output tgl_ctl_t         ctl [NUM_GEN]
);

    for (genvar g = 0; g < NUM_GEN; g++) begin : g_dec
        logic hit;
        assign hit = op_valid && (op_gen == SEL_W'(g));

        // Purpose: raise at most one strobe for the addressed generator.
        always_comb begin
            ctl[g] = '0;
            if (hit) begin
                case (op_code)
                    OP_PIN:   ctl[g].wr_pin   = 1'b1;
                    OP_HIGH:  ctl[g].wr_high  = 1'b1;
                    OP_LOW:   ctl[g].wr_low   = 1'b1;
                    OP_COUNT: ctl[g].wr_count = 1'b1;
                    OP_START: ctl[g].start    = 1'b1;
                    OP_CLEAR: ctl[g].clear    = 1'b1;
                    default:  ctl[g]          = '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/tgl_gen.sv
// Module: one toggle generator with bus-cycle prescaler, interval down
// counter, repeat counter and output level.
// Assumes: CLK_PER_BUS >= 2; the pin mask is restricted to ALLOW_MASK.
module tgl_gen
    import tgl_pkg::*;
#(
    parameter int               PORT_W      = 8,
    parameter int               CNT_W       = 32,
    parameter int               CLK_PER_BUS = 4,
    parameter logic [PORT_W-1:0] ALLOW_MASK = 8'h87
) (
    input  logic              clk,
    input  logic              rst_n,
    input  tgl_ctl_t          ctl,
    input  logic              halt,
    input  logic [CNT_W-1:0]  data,
    output logic [PORT_W-1:0] pin_mask,
    output logic              level,
    output logic              busy
);

    localparam int PH_W = (CLK_PER_BUS > 1) ? $clog2(CLK_PER_BUS) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(CLK_PER_BUS - 1);

    logic [CNT_W-1:0] high_t, low_t, count, cnt;
    logic [PH_W-1:0]  ph;
    logic [PORT_W-1:0] cand;
    logic [CNT_W-1:0] first_iv, next_iv, clamped;
    logic             expire;

    // Purpose: isolate the lowest permitted bit of the written pin data.
    always_comb begin
        cand = data[PORT_W-1:0] & ALLOW_MASK;
        cand = cand & (~cand + PORT_W'(1));
    end

    // Purpose: pick the first and the follow-on interval from the level.
    always_comb begin
        first_iv = level ? high_t : low_t;
        next_iv  = level ? low_t  : high_t;
        clamped  = (data == '0) ? CNT_W'(1) : data;
        expire   = busy && (ph == PH_LAST) && (cnt == CNT_W'(1));
    end

    // Purpose: hold the configuration written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_mask <= '0;
            high_t   <= '0;
            low_t    <= '0;
        end else begin
            if (ctl.wr_pin)  pin_mask <= cand;
            if (ctl.wr_high) high_t   <= clamped;
            if (ctl.wr_low)  low_t    <= clamped;
        end
    end

    // Purpose: maintain the remaining-flip count.
    always_ff @(posedge clk) begin
        if (!rst_n)                             count <= '0;
        else if (ctl.clear)                     count <= '0;
        else if (ctl.wr_count)                  count <= data;
        else if (expire && !halt && !ctl.start && count != '0)
                                                count <= count - CNT_W'(1);
    end

    // Purpose: run the prescaler, interval counter and level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            level <= 1'b0;
            cnt   <= '0;
            ph    <= '0;
        end else if (halt || ctl.clear) begin
            busy <= 1'b0;
        end else if (ctl.start) begin
            ph   <= '0;
            cnt  <= first_iv;
            busy <= (first_iv != '0);
        end else if (busy) begin
            if (ph == PH_LAST) begin
                ph <= '0;
                if (cnt == CNT_W'(1)) begin
                    level <= ~level;
                    if (count != '0 && next_iv != '0) cnt <= next_iv;
                    else                              busy <= 1'b0;
                end else begin
                    cnt <= cnt - CNT_W'(1);
                end
            end else begin
                ph <= ph + PH_W'(1);
            end
        end
    end

    // R11: a pending flip always has a live interval.
    a_r11_busy_has_interval: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt != '0));
    // R3: at most one pin claimed.
    a_r3_one_pin: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pin_mask));
    // R9: clear cancels and zeroes the count.
    a_r9_clear_stops: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.clear |=> (!busy && count == '0));
    // R10: halt cancels.
    a_r10_halt_stops: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> !busy);
    // R6: level moves only out of a pending interval.
    a_r6_level_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(level) |-> $past(busy));
    // R6: count never grows without a write.
    a_r6_count_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl.wr_count |=> (count <= $past(count)));

endmodule

// File: rtl/tgl_merge.sv
// Module: overlays generator levels onto the incoming port value.
// Assumes: each mask is one-hot or zero; lower index has priority.
module tgl_merge #(
    parameter int NUM_GEN = 4,
    parameter int PORT_W  = 8
) (
    input  logic [PORT_W-1:0]  pin_in,
    input  logic [PORT_W-1:0]  masks [NUM_GEN],
    input  logic [NUM_GEN-1:0] levels,
    output logic [PORT_W-1:0]  pin_out
);

    // Purpose: apply generators from highest to lowest so index 0 wins.
    always_comb begin
        pin_out = pin_in;
        for (int g = NUM_GEN - 1; g >= 0; g--) begin
            pin_out = (pin_out & ~masks[g]) | (masks[g] & {PORT_W{levels[g]}});
        end
    end

endmodule

// File: rtl/pin_toggler.sv
// Module: top of the programmable input pin toggler.
// Assumes: one command per cycle; halt_all is a one-cycle pulse.
module pin_toggler
    import tgl_pkg::*;
#(
    parameter int               NUM_GEN     = 4,
    parameter int               PORT_W      = 8,
    parameter int               CNT_W       = 32,
    parameter int               CLK_PER_BUS = 4,
    parameter logic [PORT_W-1:0] ALLOW_MASK = 8'h87,
    localparam int              SEL_W       = $clog2(NUM_GEN + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               op_valid,
    input  logic [2:0]         op_code,
    input  logic [SEL_W-1:0]   op_gen,
    input  logic [CNT_W-1:0]   op_data,
    input  logic               halt_all,
    input  logic [PORT_W-1:0]  pin_in,
    output logic [PORT_W-1:0]  pin_out,
    output logic [NUM_GEN-1:0] gen_busy
);

    tgl_ctl_t           ctl [NUM_GEN];
    logic [PORT_W-1:0]  masks [NUM_GEN];
    logic [NUM_GEN-1:0] levels;

    tgl_decode #(.NUM_GEN(NUM_GEN), .SEL_W(SEL_W)) u_dec (
        .op_valid (op_valid),
        .op_code  (op_code),
        .op_gen   (op_gen),
        .ctl      (ctl)
    );

    for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
        tgl_gen #(
            .PORT_W      (PORT_W),
            .CNT_W       (CNT_W),
            .CLK_PER_BUS (CLK_PER_BUS),
            .ALLOW_MASK  (ALLOW_MASK)
        ) u_gen (
            .clk      (clk),
            .rst_n    (rst_n),
            .ctl      (ctl[g]),
            .halt     (halt_all),
            .data     (op_data),
            .pin_mask (masks[g]),
            .level    (levels[g]),
            .busy     (gen_busy[g])
        );
    end

    tgl_merge #(.NUM_GEN(NUM_GEN), .PORT_W(PORT_W)) u_merge (
        .pin_in  (pin_in),
        .masks   (masks),
        .levels  (levels),
        .pin_out (pin_out)
    );

    // R12: pins that no generator may claim pass straight through.
    a_r12_outside_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_out ^ pin_in) & ~ALLOW_MASK) == '0);

endmodule

// File: tb/tb_pin_toggler.sv
module tb_pin_toggler;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_code = '0;
    logic [2:0]  op_gen = '0;
    logic [31:0] op_data = '0;
    logic        halt_all = 1'b0;
    logic [7:0]  pin_in = 8'h5A;
    logic [7:0]  pin_out;
    logic [3:0]  gen_busy;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    pin_toggler dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_gen(op_gen), .op_data(op_data), .halt_all(halt_all),
        .pin_in(pin_in), .pin_out(pin_out), .gen_busy(gen_busy)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic op(input logic [2:0] code, input logic [2:0] gen, input logic [31:0] d);
        op_valid = 1'b1; op_code = code; op_gen = gen; op_data = d;
        @(negedge clk);
        op_valid = 1'b0; op_code = '0; op_gen = '0; op_data = '0;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);
        chk("R1 pin_out after reset", pin_out, 8'h5A);
        chk("R1 busy after reset", gen_busy, 4'h0);
        pin_in = 8'hFF;
    endtask

    task automatic t_decode();
        op(3'd0, 3'd0, 32'hFF);   // gen0 takes bit0
        op(3'd0, 3'd1, 32'h78);   // nothing allowed, no pin
        chk("R3 lowest allowed bit claimed", pin_out, 8'hFE);
        op(3'd0, 3'd1, 32'hC0);   // gen1 takes bit7
        chk("R3 second pin claimed", pin_out, 8'h7E);
        op(3'd0, 3'd5, 32'h04);   // out-of-range generator
        op(3'd6, 3'd1, 32'h04);   // unused code
        chk("R2 ignored commands leave pins", pin_out, 8'h7E);
        chk("R12 unclaimable pins pass", pin_out & 8'h78, 8'h78);
    endtask

    task automatic t_timing();
        op(3'd1, 3'd0, 32'd3);
        op(3'd2, 3'd0, 32'd2);
        op(3'd3, 3'd0, 32'd2);
        op(3'd4, 3'd0, 32'd0);
        wait_n(7);
        chk("R4 before first flip", pin_out[0], 1'b0);
        chk("R11 busy while pending", gen_busy[0], 1'b1);
        wait_n(1);
        chk("R4 flip after 4*low", pin_out[0], 1'b1);
        wait_n(11);
        chk("R5 high lasts high time", pin_out[0], 1'b1);
        wait_n(1);
        chk("R5 flip after 4*high", pin_out[0], 1'b0);
        wait_n(7);
        chk("R5 low lasts low time", pin_out[0], 1'b0);
        wait_n(1);
        chk("R6 third flip", pin_out[0], 1'b1);
        chk("R6 idle after N+1 flips", gen_busy[0], 1'b0);
        wait_n(20);
        chk("R6 level held when idle", pin_out[0], 1'b1);
    endtask

    task automatic t_level_start();
        op(3'd3, 3'd0, 32'd0);
        op(3'd4, 3'd0, 32'd0);    // level 1 -> high time 3
        wait_n(11);
        chk("R7 high level starts with high time", pin_out[0], 1'b1);
        wait_n(1);
        chk("R7 flip at 4*high", pin_out[0], 1'b0);
        chk("R6 single flip with count 0", gen_busy[0], 1'b0);
    endtask

    task automatic t_cancel();
        op(3'd3, 3'd0, 32'd5);
        op(3'd4, 3'd0, 32'd0);
        wait_n(4);
        op(3'd4, 3'd0, 32'd0);    // restart cancels old deadline
        wait_n(3);
        chk("R7 old deadline cancelled", pin_out[0], 1'b0);
        wait_n(4);
        chk("R7 new interval not yet over", pin_out[0], 1'b0);
        wait_n(1);
        chk("R7 flip at new deadline", pin_out[0], 1'b1);
    endtask

    task automatic t_clear();
        op(3'd5, 3'd0, 32'd0);
        chk("R9 clear cancels", gen_busy[0], 1'b0);
        wait_n(20);
        chk("R9 level kept after clear", pin_out[0], 1'b1);
        op(3'd4, 3'd0, 32'd0);
        wait_n(11);
        chk("R9 restart after clear", pin_out[0], 1'b1);
        wait_n(1);
        chk("R9 one flip after clear", pin_out[0], 1'b0);
        chk("R9 count was zeroed", gen_busy[0], 1'b0);
    endtask

    task automatic t_zero();
        op(3'd0, 3'd2, 32'h04);
        op(3'd1, 3'd2, 32'd5);
        op(3'd4, 3'd2, 32'd0);    // low time never written
        chk("R8 unwritten interval stays idle", gen_busy[2], 1'b0);
        chk("R8 pin driven low", pin_out[2], 1'b0);
        op(3'd0, 3'd3, 32'h02);
        op(3'd2, 3'd3, 32'd0);    // stored as 1
        op(3'd4, 3'd3, 32'd0);
        wait_n(3);
        chk("R4 zero clamp before", pin_out[1], 1'b0);
        wait_n(1);
        chk("R4 zero clamped to one bus cycle", pin_out[1], 1'b1);
        chk("R4 idle afterwards", gen_busy[3], 1'b0);
    endtask

    task automatic t_halt();
        op(3'd2, 3'd2, 32'd2);
        op(3'd3, 3'd2, 32'd100);
        op(3'd1, 3'd3, 32'd4);
        op(3'd3, 3'd3, 32'd100);
        op(3'd4, 3'd2, 32'd0);
        op(3'd4, 3'd3, 32'd0);
        chk("R11 both busy", gen_busy[3:2], 2'b11);
        halt_all = 1'b1;
        wait_n(1);
        halt_all = 1'b0;
        chk("R10 halt cancels all", gen_busy, 4'h0);
        wait_n(30);
        chk("R10 levels kept gen2", pin_out[2], 1'b0);
        chk("R10 levels kept gen3", pin_out[1], 1'b1);
        op(3'd4, 3'd2, 32'd0);
        chk("R10 settings survive halt", gen_busy[2], 1'b1);
        wait_n(7);
        chk("R10 restart timing before", pin_out[2], 1'b0);
        wait_n(1);
        chk("R10 restart timing flip", pin_out[2], 1'b1);
        op(3'd5, 3'd2, 32'd0);
    endtask

    task automatic t_prio();
        op(3'd0, 3'd3, 32'h80);
        chk("R3 lower index wins shared pin", pin_out[7], 1'b0);
        op(3'd0, 3'd1, 32'h00);
        chk("R3 next owner drives pin", pin_out, 8'hFE);
    endtask

    initial begin
        t_reset();
        t_decode();
        t_timing();
        t_level_start();
        t_cancel();
        t_clear();
        t_zero();
        t_halt();
        t_prio();
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule